// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Channel

This block is one timer channel controlled through a simple 32-bit register bus. The input clock passes through two dividers. The first is an 8-bit prescaler that divides by its setting plus one. The second is a power-of-two divider selected by a 4-bit code. Each divided tick lowers a 32-bit active counter by one.

Software writes a period into a count buffer and a threshold into a compare buffer. A manual update strobe copies both buffers into the active registers while the channel is stopped. When the channel is enabled, the counter runs down to zero. If auto-reload is on, it then refills from the buffer as the buffer stands at that moment, so software can stage the next period while the current one runs. If auto-reload is off, the channel stops itself.

Every expiry sets a sticky status flag, which software clears by writing one to it. The flag drives the interrupt line when its enable bit is set. Software can read the live count at any time. A waveform output compares the count against the active threshold and can be inverted.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset every register reads zero, and `irq` and `tout` are low.
- R2: The counter is stepped once every (P+1)·2^D clock cycles. P is the prescale field, bits [7:0] at offset 0x00. D is the divider code, bits [3:0] at offset 0x04, and D=0 adds no division.
- R3: While control bit 1 (update) at offset 0x08 is 1, the count buffer (0x0C) and compare buffer (0x10) are copied into the active counter and threshold, and the prescaler restarts. Reading 0x14 then returns the loaded count.
- R4: The counter decrements only while control bit 0 (enable) is 1 and update is 0. An expiry is a step taken while the count is 0, so a loaded value N gives a period of N+1 steps. While the channel is disabled the count holds.
- R5: With control bit 3 (auto-reload) set, an expiry reloads the counter from the count buffer's current contents. A buffer write made after a manual load therefore sets the length of the following period.
- R6: With auto-reload clear, an expiry leaves the counter at 0 and clears the enable bit.
- R7: Bit 5 at offset 0x44 is the expiry status. It is set by every expiry and stays set until a write with bit 5 = 1 clears it. An expiry in the same cycle as a clear keeps it set.
- R8: `irq` is high exactly when the status bit and interrupt enable bit 0 at offset 0x44 are both 1. It becomes valid in the cycle after either of them changes.
- R9: `tout` is registered and equals control bit 2 (invert) XOR (the channel is running and count ≤ active threshold).
- R10: Offset 0x14 is read-only, so writes to it have no effect. Unmapped offsets read as zero.
- R11: Interrupt enable bits [4:1] at 0x44 and control bit 4 are stored and read back, and have no effect on counting or on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid the next cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request, level |
| tout | output | 1 | Registered waveform output |

## Verification
The bench programs random prescale, divider and period values and times the cycles from enable to the first interrupt. A divider that is off by one, or a missing N+1 term, would shift that count. It then clears the status and times the second period against a buffer value that was staged after the manual load. A design that reloaded from a stale copy would repeat the first period, and one whose clear lost to a same-cycle set would leave the interrupt stuck or dropped. Directed cases cover the one-shot stop, interrupt gating through the enable bit, writes to the read-only count register, stub bits, and the inverted waveform output.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam logic [7:0] OFS_PRESC = 8'h00;
  localparam logic [7:0] OFS_DIVSEL = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_CBUF  = 8'h0C;
  localparam logic [7:0] OFS_MBUF  = 8'h10;
  localparam logic [7:0] OFS_OBS   = 8'h14;
  localparam logic [7:0] OFS_INT   = 8'h44;

  localparam int CTL_RUN  = 0;
  localparam int CTL_UPD  = 1;
  localparam int CTL_INV  = 2;
  localparam int CTL_AR   = 3;
  localparam int CTL_DZ   = 4;
  localparam int CTL_W    = 5;

  localparam int INT_EN_W = 5;
  localparam int INT_STAT = 5;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_val,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int DCNT_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0]  pre_cnt;
  logic [DCNT_W-1:0] div_cnt;
  logic [DCNT_W-1:0] div_mask;
  logic              pre_hit;

  always_comb begin
    div_mask = (DCNT_W'(1) << div_sel) - DCNT_W'(1);
    pre_hit  = run && (pre_cnt == pre_val);
    tick     = pre_hit && ((div_cnt & div_mask) == div_mask);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (run) begin
      pre_cnt <= pre_hit ? '0 : pre_cnt + PRE_W'(1);
      if (pre_hit) div_cnt <= div_cnt + DCNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          run,
  input  logic          tick,
  input  logic          auto_rl,
  input  logic          invert,
  input  logic [CW-1:0] cnt_buf,
  input  logic [CW-1:0] cmp_buf,
  output logic [CW-1:0] count,
  output logic          expire,
  output logic          tout
);
  logic [CW-1:0] cmp_act;

  assign expire = run && tick && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      cmp_act <= '0;
      tout    <= 1'b0;
    end else begin
      if (load) begin
        count   <= cnt_buf;
        cmp_act <= cmp_buf;
      end else if (expire) begin
        count <= auto_rl ? cnt_buf : '0;
      end else if (run && tick) begin
        count <= count - CW'(1);
      end
      tout <= invert ^ (run && (count <= cmp_act));
    end
  end
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int PRE_W = 8,
  parameter int DIV_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          tout
);
  logic [PRE_W-1:0]    presc_q;
  logic [DIV_W-1:0]    divsel_q;
  logic [CTL_W-1:0]    ctrl_q;
  logic [DW-1:0]       cbuf_q;
  logic [DW-1:0]       mbuf_q;
  logic [INT_EN_W-1:0] ien_q;
  logic                stat_q;
  logic                stat_d;
  logic                tick_w;
  logic                expire_w;
  logic                run_w;
  logic [DW-1:0]       count_w;
  logic                wr_ctrl, wr_int, stop_w;

  assign run_w   = ctrl_q[CTL_RUN] && !ctrl_q[CTL_UPD];
  assign wr_ctrl = bus_wr && (bus_addr == AW'(OFS_CTRL));
  assign wr_int  = bus_wr && (bus_addr == AW'(OFS_INT));
  assign stop_w  = expire_w && !ctrl_q[CTL_AR];

  pwm_tick_gen #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run_w), .restart(ctrl_q[CTL_UPD]),
    .pre_val(presc_q), .div_sel(divsel_q), .tick(tick_w)
  );

  pwm_down_counter #(.CW(DW)) u_cnt (
    .clk(clk), .rst(rst), .load(ctrl_q[CTL_UPD]), .run(run_w), .tick(tick_w),
    .auto_rl(ctrl_q[CTL_AR]), .invert(ctrl_q[CTL_INV]),
    .cnt_buf(cbuf_q), .cmp_buf(mbuf_q),
    .count(count_w), .expire(expire_w), .tout(tout)
  );

  always_comb begin
    stat_d = stat_q;
    if (wr_int && bus_wdata[INT_STAT]) stat_d = 1'b0;
    if (expire_w) stat_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q  <= '0;
      divsel_q <= '0;
      ctrl_q   <= '0;
      cbuf_q   <= '0;
      mbuf_q   <= '0;
      ien_q    <= '0;
      stat_q   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == AW'(OFS_PRESC))  presc_q  <= bus_wdata[PRE_W-1:0];
      if (bus_wr && bus_addr == AW'(OFS_DIVSEL)) divsel_q <= bus_wdata[DIV_W-1:0];
      if (bus_wr && bus_addr == AW'(OFS_CBUF))   cbuf_q   <= bus_wdata;
      if (bus_wr && bus_addr == AW'(OFS_MBUF))   mbuf_q   <= bus_wdata;
      if (wr_ctrl)      ctrl_q <= bus_wdata[CTL_W-1:0];
      else if (stop_w)  ctrl_q[CTL_RUN] <= 1'b0;
      if (wr_int) ien_q <= bus_wdata[INT_EN_W-1:0];
      stat_q <= stat_d;
      irq    <= stat_d && (wr_int ? bus_wdata[0] : ien_q[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        AW'(OFS_PRESC):  bus_rdata <= DW'(presc_q);
        AW'(OFS_DIVSEL): bus_rdata <= DW'(divsel_q);
        AW'(OFS_CTRL):   bus_rdata <= DW'(ctrl_q);
        AW'(OFS_CBUF):   bus_rdata <= cbuf_q;
        AW'(OFS_MBUF):   bus_rdata <= mbuf_q;
        AW'(OFS_OBS):    bus_rdata <= count_w;
        AW'(OFS_INT):    bus_rdata <= DW'({stat_q, ien_q});
        default:         bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          expire,
  input logic          run,
  input logic          upd,
  input logic          auto_rl,
  input logic          ctl_en,
  input logic          wr_ctrl,
  input logic          stat,
  input logic          ien0,
  input logic          irq,
  input logic [CW-1:0] count,
  input logic [CW-1:0] cbuf
);
  AST_LOAD_FROM_BUF: assert property (@(posedge clk) disable iff (rst)
    upd |=> (count == $past(cbuf))); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (run && tick && count != '0) |=> (count == $past(count) - CW'(1))); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!run && !upd) |=> $stable(count)); // R4
  AST_RELOAD_BUF: assert property (@(posedge clk) disable iff (rst)
    (expire && auto_rl) |=> (count == $past(cbuf))); // R5
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (expire && !auto_rl && !wr_ctrl) |=> (!ctl_en && count == '0)); // R6
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (rst)
    expire |=> stat); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat && ien0)); // R8
endmodule

bind pwm_timer_chan pwm_timer_chk #(.CW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_w), .expire(expire_w), .run(run_w),
  .upd(ctrl_q[1]), .auto_rl(ctrl_q[3]), .ctl_en(ctrl_q[0]), .wr_ctrl(wr_ctrl),
  .stat(stat_q), .ien0(ien_q[0]), .irq(irq), .count(count_w), .cbuf(cbuf_q)
);

// File: tb/pwm_timer_chan_test.sv
module pwm_timer_chan_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, tout;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  pwm_timer_chan uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tout(tout)
  );

  function automatic int period_cycles(int p, int d, int n);
    return (n + 1) * (p + 1) * (1 << d);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(output int m);
    m = 0;
    while (m < 5000) begin
      @(negedge clk);
      m++;
      if (irq) break;
    end
  endtask

  task automatic load(int n);
    wr(8'h0C, n);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] offs [7] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h44};
    int m;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    foreach (offs[i]) begin
      rd(offs[i], v);
      chk("R1 reg reset", v, 32'h0);
    end
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    chk("R1 tout reset", {31'b0, tout}, 32'h0);

    // R11 stub bits
    wr(8'h44, 32'h1E);
    wr(8'h08, 32'h10);
    rd(8'h44, v); chk("R11 int stub enables", v, 32'h1E);
    rd(8'h08, v); chk("R11 ctrl stub bit", v, 32'h10);
    chk("R11 irq unaffected", {31'b0, irq}, 32'h0);
    wr(8'h44, 32'h0);
    wr(8'h08, 32'h0);

    // R3 manual load, R10 read-only / unmapped
    wr(8'h10, 32'h40);
    load(32'h30);
    rd(8'h14, v); chk("R3 loaded count", v, 32'h30);
    wr(8'h14, 32'hDEAD);
    rd(8'h14, v); chk("R10 obs write ignored", v, 32'h30);
    rd(8'h20, v); chk("R10 unmapped reads zero", v, 32'h0);
    repeat (5) @(negedge clk);
    rd(8'h14, v); chk("R4 holds while disabled", v, 32'h30);

    // R9 waveform output
    wr(8'h08, 32'h4);
    repeat (2) @(negedge clk);
    chk("R9 inverted idle", {31'b0, tout}, 32'h1);
    wr(8'h00, 32'hFF);
    wr(8'h04, 32'hF);
    wr(8'h08, 32'h1);
    repeat (2) @(negedge clk);
    chk("R9 count<=cmp running", {31'b0, tout}, 32'h1);
    wr(8'h08, 32'h5);
    repeat (2) @(negedge clk);
    chk("R9 count<=cmp inverted", {31'b0, tout}, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h10, 32'h10);
    load(32'h30);
    wr(8'h08, 32'h1);
    repeat (2) @(negedge clk);
    chk("R9 count>cmp running", {31'b0, tout}, 32'h0);
    wr(8'h08, 32'h0);

    // R2 R4 R5 R7 random auto-reload trials
    for (int t = 0; t < 6; t++) begin
      int p, d, n1, n2;
      p  = $urandom_range(3, 0);
      d  = $urandom_range(2, 0);
      n1 = $urandom_range(9, 2);
      n2 = $urandom_range(9, 2);
      if (t == 0) begin p = 0; d = 0; end
      wr(8'h00, p);
      wr(8'h04, d);
      wr(8'h44, 32'h21);
      load(n1);
      wr(8'h0C, n2);
      wr(8'h08, 32'h9);
      wait_irq(m);
      chk("R2 R4 first period", m, period_cycles(p, d, n1));
      wr(8'h44, 32'h21);
      chk("R7 clear drops irq", {31'b0, irq}, 32'h0);
      wait_irq(m);
      chk("R5 staged reload period", m, period_cycles(p, d, n2) - 1);
      wr(8'h08, 32'h0);
    end

    // R8 gating by enable
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h44, 32'h20);
    load(3);
    wr(8'h08, 32'h9);
    repeat (10) @(negedge clk);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    rd(8'h44, v); chk("R7 status set while masked", v, 32'h20);
    wr(8'h44, 32'h01);
    chk("R8 irq after enable", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h0);

    // R6 one-shot
    wr(8'h44, 32'h21);
    load(4);
    wr(8'h08, 32'h1);
    repeat (20) @(negedge clk);
    rd(8'h08, v); chk("R6 enable cleared", v, 32'h0);
    rd(8'h14, v); chk("R6 count at zero", v, 32'h0);
    rd(8'h44, v); chk("R6 R7 status set", v, 32'h21);

    // R7 set wins over clear (expiry every cycle)
    load(0);
    wr(8'h08, 32'h9);
    repeat (3) @(negedge clk);
    wr(8'h44, 32'h21);
    rd(8'h44, v); chk("R7 set beats clear", v, 32'h21);
    wr(8'h08, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule